// File: doc/BRIEF.md
# Erase/write cycle timer

This block sets how long the programming phase of a small serial EEPROM lasts. The bus controller latches between one and eight data bytes. When the transfer ends it pulses `start` together with the byte count. The timer then raises `busy`. It walks through the latched bytes and sends erase and write strobes, each tagged with a byte index, to the memory array model. After a last settle tick it drops `busy` and gives a one-cycle `done` pulse.

The length of each phase is counted in base ticks, and there are two time bases.
- **Internal:** the `osc_tick` pulse train passes through two cascaded dividers, by `DIV_LO` and then by `DIV_HI`.
- **External:** rising edges of `ext_clk`, counted after a two-stage synchroniser.

The controller picks the time base during the addressing phase. It pulses `cap_stb` at the moment the control level `mode_ctl` is valid: a low level selects the external clock and a high level selects the internal time base. The choice holds for the whole cycle. On completion, and on reset, the block returns to the internal time base.

There are two sequencing modes.
- **Byte mode (one to seven bytes):** each byte gets an erase half, then a write half of the same length.
- **Page mode (eight bytes):** one phase erases the whole page, then one write phase follows for each byte. All nine phases have the same length.

With the default parameters and an external clock, the cycle needs 257, 513, n×256+1 or 1153 external edges.

The sequencer is a four-state machine:
- **IDLE → ERASE** on an accepted start.
- **ERASE → WRITE** when the erase phase ends.
- **WRITE → ERASE** (byte mode) or **WRITE → WRITE** (page mode) when a write phase ends and bytes remain.
- **WRITE → SETTLE** after the last byte is written.
- **SETTLE → IDLE** on the next base tick, which also produces `done`.

Top module: `ew_cycle_timer`

## Requirements
- R1: After reset, `busy`, `done`, `erase_stb`, `erase_all` and `write_stb` are low and the internal time base is selected.
- R2: A `cap_stb` pulse while idle selects the external clock if `mode_ctl` is 0 and the internal time base if it is 1. A `cap_stb` while busy has no effect on the running cycle.
- R3: `start` while idle raises `busy` in the next cycle and latches `byte_count` (value n-1 for n bytes). `start` while busy is ignored.
- R4: In byte mode (`byte_count` 0 to 6), byte k gets an erase strobe at base tick (2k+1)·H and a write strobe at (2k+2)·H, both with `byte_idx`=k. H is the half length of the selected time base.
- R5: In page mode (`byte_count`=7), one erase strobe with `erase_all`=1 and `byte_idx`=0 comes at tick P. The write strobe for byte k comes at (k+2)·P.
- R6: With the external clock (H=P=128 edges), `done` follows edge 257 for one byte, 513 for two, n·256+1 for n bytes, and 1153 for a page.
- R7: With the internal time base, one base tick is DIV_LO·DIV_HI oscillator ticks. Here H=INT_HALF and P=INT_PAGE. `done` comes one tick after the last write.
- R8: `done` is a single-cycle pulse in the cycle where `busy` falls. The next cycle started without a capture uses the internal time base.
- R9: The source that is not selected (oscillator ticks in external mode, external edges in internal mode) has no effect on timing.
- R10: Erase and write strobes never occur in the same cycle and only occur while `busy` is high. Write indices run 0 to n-1 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator |
| ext_clk | input | 1 | External programming clock level (asynchronous) |
| mode_ctl | input | 1 | Time-base select level: 0 external, 1 internal |
| cap_stb | input | 1 | Samples `mode_ctl` while idle |
| byte_count | input | $clog2(PAGE_BYTES) | Number of latched bytes minus one |
| start | input | 1 | Starts the programming cycle |
| busy | output | 1 | High from accepted start to completion |
| done | output | 1 | One-cycle completion pulse |
| erase_stb | output | 1 | Erase strobe for `byte_idx` |
| erase_all | output | 1 | Qualifies `erase_stb` as a whole-page erase |
| write_stb | output | 1 | Write strobe for `byte_idx` |
| byte_idx | output | $clog2(PAGE_BYTES) | Byte index for the current strobe |

## Verification
The checker watches the properties that hold on every cycle:
- erase and write strobes never overlap;
- strobes appear only while busy;
- `done` is one cycle long and coincides with `busy` falling;
- an accepted start raises `busy`;
- `erase_all` never appears without an erase strobe.

Only the bench scenarios can show the following:
- the exact tick at which each strobe and `done` appears, for the external counts 257, 513, 1793 and 1153 and for internal byte and page runs;
- the index order of the strobes;
- that a capture or start arriving mid-cycle leaves the timing unchanged;
- that the block falls back to the internal time base after a cycle.

// File: rtl/ewt_pkg.sv
package ewt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ERASE  = 2'd1,
        ST_WRITE  = 2'd2,
        ST_SETTLE = 2'd3
    } ewt_state_t;

    typedef enum logic {
        TB_INTERNAL = 1'b0,
        TB_EXTERNAL = 1'b1
    } ewt_base_t;

endpackage

// File: rtl/ewt_divider.sv
// One divide stage: emits one pulse per DIV input pulses; clr restarts the count.
module ewt_divider #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic tick_out
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt_q;
    logic          at_last;

    assign at_last  = (cnt_q == LAST);
    assign tick_out = tick_in && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= at_last ? '0 : cnt_q + DW'(1);
        end
    end
endmodule

// File: rtl/ewt_prescaler.sv
// Cascade of divide stages turning oscillator pulses into internal base ticks.
module ewt_prescaler #(
    parameter int DIV_LO = 128,
    parameter int DIV_HI = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic osc_tick,
    output logic int_tick
);
    localparam int STAGES = 2;

    logic [STAGES:0] carry;

    assign carry[0] = osc_tick;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int SD = (g == 0) ? DIV_LO : DIV_HI;
        ewt_divider #(.DIV(SD)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (clr),
            .tick_in  (carry[g]),
            .tick_out (carry[g+1])
        );
    end

    assign int_tick = carry[STAGES];
endmodule

// File: rtl/ewt_edge_sync.sv
// Synchronises the external programming clock and flags each rising edge.
module ewt_edge_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic ext_rise
);
    logic [SYNC:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SYNC-1:0], ext_clk};
        end
    end

    assign ext_rise = sh_q[SYNC-1] & ~sh_q[SYNC];
endmodule

// File: rtl/ewt_sequencer.sv
// Phase sequencer: mode capture, per-byte erase/write phases, settle tick.
module ewt_sequencer
    import ewt_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int INT_HALF   = 1,
    parameter int INT_PAGE   = 2,
    parameter int EXT_HALF   = 128,
    parameter int EXT_PAGE   = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          int_tick,
    input  logic                          ext_tick,
    input  logic                          mode_ctl,
    input  logic                          cap_stb,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_count,
    input  logic                          start,
    output logic                          pre_clr,
    output logic                          busy,
    output logic                          done,
    output logic                          erase_stb,
    output logic                          erase_all,
    output logic                          write_stb,
    output logic [$clog2(PAGE_BYTES)-1:0] byte_idx
);
    localparam int IW      = $clog2(PAGE_BYTES);
    localparam int MAX_A   = (INT_HALF > INT_PAGE) ? INT_HALF : INT_PAGE;
    localparam int MAX_B   = (EXT_HALF > EXT_PAGE) ? EXT_HALF : EXT_PAGE;
    localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_LEN) + 1;

    localparam logic [CW-1:0] END_INT_HALF = CW'(INT_HALF - 1);
    localparam logic [CW-1:0] END_INT_PAGE = CW'(INT_PAGE - 1);
    localparam logic [CW-1:0] END_EXT_HALF = CW'(EXT_HALF - 1);
    localparam logic [CW-1:0] END_EXT_PAGE = CW'(EXT_PAGE - 1);
    localparam logic [IW-1:0] PAGE_CODE    = IW'(PAGE_BYTES - 1);

    ewt_state_t     state_q, state_d;
    logic [CW-1:0]  tcnt_q, tcnt_d;
    logic [IW-1:0]  idx_q, idx_d;
    logic [IW-1:0]  last_q;
    logic           page_q;
    ewt_base_t      base_q;

    logic           accept;
    logic           base_tick;
    logic [CW-1:0]  phase_end_cnt;
    logic           at_end;
    logic           erase_done, write_done, settle_done;

    // ---------------- time-base selection and phase end ----------------
    assign accept    = start && (state_q == ST_IDLE);
    assign pre_clr   = accept;
    assign base_tick = (base_q == TB_EXTERNAL) ? ext_tick : int_tick;

    always_comb begin
        if (base_q == TB_EXTERNAL) begin
            phase_end_cnt = page_q ? END_EXT_PAGE : END_EXT_HALF;
        end else begin
            phase_end_cnt = page_q ? END_INT_PAGE : END_INT_HALF;
        end
    end

    assign at_end      = base_tick && (tcnt_q == phase_end_cnt);
    assign erase_done  = (state_q == ST_ERASE) && at_end;
    assign write_done  = (state_q == ST_WRITE) && at_end;
    assign settle_done = (state_q == ST_SETTLE) && base_tick;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_ERASE;
                    tcnt_d  = '0;
                    idx_d   = '0;
                end
            end
            ST_ERASE: begin
                if (at_end) begin
                    state_d = ST_WRITE;
                    tcnt_d  = '0;
                end else if (base_tick) begin
                    tcnt_d = tcnt_q + CW'(1);
                end
            end
            ST_WRITE: begin
                if (at_end) begin
                    tcnt_d = '0;
                    if (idx_q == last_q) begin
                        state_d = ST_SETTLE;
                    end else begin
                        idx_d   = idx_q + IW'(1);
                        state_d = page_q ? ST_WRITE : ST_ERASE;
                    end
                end else if (base_tick) begin
                    tcnt_d = tcnt_q + CW'(1);
                end
            end
            ST_SETTLE: begin
                if (base_tick) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- phase counter, index and cycle context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            idx_q  <= '0;
            last_q <= '0;
            page_q <= 1'b0;
            base_q <= TB_INTERNAL;
        end else begin
            tcnt_q <= tcnt_d;
            idx_q  <= idx_d;
            if (accept) begin
                last_q <= byte_count;
                page_q <= (byte_count == PAGE_CODE);
            end
            if (state_q == ST_IDLE && cap_stb) begin
                base_q <= mode_ctl ? TB_INTERNAL : TB_EXTERNAL;
            end else if (settle_done) begin
                base_q <= TB_INTERNAL;
            end
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            erase_stb <= 1'b0;
            erase_all <= 1'b0;
            write_stb <= 1'b0;
            byte_idx  <= '0;
        end else begin
            busy      <= (state_d != ST_IDLE);
            done      <= settle_done;
            erase_stb <= erase_done;
            erase_all <= erase_done && page_q;
            write_stb <= write_done;
            if (erase_done || write_done) begin
                byte_idx <= idx_q;
            end
        end
    end
endmodule

// File: rtl/ew_cycle_timer.sv
// Top: erase/write cycle timer with internal and external time bases.
module ew_cycle_timer #(
    parameter int PAGE_BYTES = 8,
    parameter int DIV_LO     = 128,
    parameter int DIV_HI     = 16,
    parameter int INT_HALF   = 1,
    parameter int INT_PAGE   = 2,
    parameter int EXT_HALF   = 128,
    parameter int EXT_PAGE   = 128,
    parameter int SYNC       = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          osc_tick,
    input  logic                          ext_clk,
    input  logic                          mode_ctl,
    input  logic                          cap_stb,
    input  logic [$clog2(PAGE_BYTES)-1:0] byte_count,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    output logic                          erase_stb,
    output logic                          erase_all,
    output logic                          write_stb,
    output logic [$clog2(PAGE_BYTES)-1:0] byte_idx
);
    logic int_tick;
    logic ext_rise;
    logic pre_clr;

    ewt_prescaler #(
        .DIV_LO (DIV_LO),
        .DIV_HI (DIV_HI)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pre_clr),
        .osc_tick (osc_tick),
        .int_tick (int_tick)
    );

    ewt_edge_sync #(.SYNC(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .ext_rise (ext_rise)
    );

    ewt_sequencer #(
        .PAGE_BYTES (PAGE_BYTES),
        .INT_HALF   (INT_HALF),
        .INT_PAGE   (INT_PAGE),
        .EXT_HALF   (EXT_HALF),
        .EXT_PAGE   (EXT_PAGE)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_tick   (int_tick),
        .ext_tick   (ext_rise),
        .mode_ctl   (mode_ctl),
        .cap_stb    (cap_stb),
        .byte_count (byte_count),
        .start      (start),
        .pre_clr    (pre_clr),
        .busy       (busy),
        .done       (done),
        .erase_stb  (erase_stb),
        .erase_all  (erase_all),
        .write_stb  (write_stb),
        .byte_idx   (byte_idx)
    );
endmodule

// File: rtl/ewt_checker.sv
// Cycle-level properties of the timer's outputs, attached by bind.
module ewt_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic erase_stb,
    input logic erase_all,
    input logic write_stb
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_stb && write_stb)); // R10

    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_stb || write_stb) |-> busy); // R10

    AST_PAGE_ERASE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |-> erase_stb); // R5

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
endmodule

bind ew_cycle_timer ewt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .erase_stb (erase_stb),
    .erase_all (erase_all),
    .write_stb (write_stb)
);

// File: tb/ew_cycle_timer_test.sv
module ew_cycle_timer_test;
    localparam int PAGE_BYTES = 8;
    localparam int IW         = $clog2(PAGE_BYTES);
    localparam int DIV_LO     = 8;
    localparam int DIV_HI     = 4;
    localparam int INT_HALF   = 1;
    localparam int INT_PAGE   = 2;
    localparam int EXT_HALF   = 128;
    localparam int EXT_PAGE   = 128;
    localparam int INT_TS     = DIV_LO * DIV_HI;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0;
    logic          ext_clk = 1'b0;
    logic          mode_ctl = 1'b1;
    logic          cap_stb = 1'b0;
    logic [IW-1:0] byte_count = '0;
    logic          start = 1'b0;
    logic          busy, done, erase_stb, erase_all, write_stb;
    logic [IW-1:0] byte_idx;

    always #4 clk = ~clk;

    ew_cycle_timer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DIV_LO     (DIV_LO),
        .DIV_HI     (DIV_HI),
        .INT_HALF   (INT_HALF),
        .INT_PAGE   (INT_PAGE),
        .EXT_HALF   (EXT_HALF),
        .EXT_PAGE   (EXT_PAGE)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_tick   (osc_tick),
        .ext_clk    (ext_clk),
        .mode_ctl   (mode_ctl),
        .cap_stb    (cap_stb),
        .byte_count (byte_count),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .erase_stb  (erase_stb),
        .erase_all  (erase_all),
        .write_stb  (write_stb),
        .byte_idx   (byte_idx)
    );

    // kind: 0 erase, 1 page erase, 2 write, 3 done
    typedef struct {
        int kind;
        int idx;
        int step;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    step_cnt = 0;
    int    disturb_step = -1;
    bit    done_seen = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // Monitor: pop expected events as the design produces strobes.
    always @(negedge clk) begin
        if (rst_n && (erase_stb || write_stb || done)) begin
            int   k;
            exp_t e;
            k = done ? 3 : (write_stb ? 2 : (erase_all ? 1 : 0));
            if (exp_q.size() == 0) begin
                chk(1'b0, cur_req, "unexpected event kind", k, -1);
            end else begin
                e = exp_q.pop_front();
                chk(k == e.kind, cur_req, "event kind", k, e.kind);
                chk(step_cnt == e.step, cur_req, "event tick", step_cnt, e.step);
                if (k != 3) begin
                    chk(int'(byte_idx) == e.idx, cur_req, "byte index", int'(byte_idx), e.idx);
                end else begin
                    chk(busy == 1'b0, "R8", "busy at done", int'(busy), 0);
                end
            end
            if (done) done_seen = 1'b1;
        end
    end

    // One step = 16 cycles with one counted pulse of the selected source;
    // the unselected source is exercised with a different rate (R9).
    task automatic tick_step(input bit ext_mode);
        for (int c = 0; c < 16; c++) begin
            cyc();
            if (ext_mode) begin
                ext_clk  = (c < 8);
                osc_tick = (c == 0 || c == 5 || c == 10);
            end else begin
                ext_clk  = ((c % 8) < 4);
                osc_tick = (c == 0);
            end
            if (c == 0) step_cnt++;
            if (c == 3 && step_cnt == disturb_step) begin
                cap_stb  = 1'b1;
                mode_ctl = 1'b0;
                start    = 1'b1;
            end else if (c == 4) begin
                cap_stb  = 1'b0;
                mode_ctl = 1'b1;
                start    = 1'b0;
            end
        end
    endtask

    task automatic run(input bit ext, input int n, input bit do_cap,
                       input int dstep, input string req);
        int ts, h, p, last;
        ts = ext ? 1 : INT_TS;
        h  = ext ? EXT_HALF : INT_HALF;
        p  = ext ? EXT_PAGE : INT_PAGE;
        cur_req = req;
        disturb_step = dstep;
        if (do_cap) begin
            cyc();
            mode_ctl = ~ext;
            cap_stb  = 1'b1;
            cyc();
            cap_stb  = 1'b0;
            mode_ctl = 1'b1;
        end
        if (n == PAGE_BYTES) begin
            exp_q.push_back('{1, 0, p * ts});
            for (int k = 0; k < n; k++) exp_q.push_back('{2, k, (k + 2) * p * ts});
            last = ((PAGE_BYTES + 1) * p + 1) * ts;
        end else begin
            for (int k = 0; k < n; k++) begin
                exp_q.push_back('{0, k, (2 * k + 1) * h * ts});
                exp_q.push_back('{2, k, (2 * k + 2) * h * ts});
            end
            last = (2 * n * h + 1) * ts;
        end
        exp_q.push_back('{3, 0, last});
        cyc();
        byte_count = IW'(n - 1);
        start = 1'b1;
        cyc();
        start = 1'b0;
        step_cnt = 0;
        done_seen = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R3", "busy after start", int'(busy), 1);
        while (!done_seen && step_cnt <= last + 2) tick_step(ext);
        chk(done_seen, req, "done observed", int'(done_seen), 1);
        repeat (3) cyc();
        chk(exp_q.size() == 0, req, "events left", exp_q.size(), 0);
        exp_q.delete();
        chk(busy == 1'b0, "R8", "busy after cycle", int'(busy), 0);
        disturb_step = -1;
    endtask

    initial begin
        repeat (4) cyc();
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(erase_stb == 1'b0 && erase_all == 1'b0, "R1", "erase", int'(erase_stb), 0);
        chk(write_stb == 1'b0, "R1", "write", int'(write_stb), 0);

        run(1'b0, 1, 1'b0, -1, "R7");          // R1 default internal, R9
        run(1'b1, 1, 1'b1, -1, "R6");          // R2 capture low: 257 edges
        run(1'b0, 1, 1'b0, -1, "R8");          // reverted to internal
        run(1'b1, 2, 1'b1, -1, "R6");          // 513 edges
        run(1'b1, 7, 1'b1, -1, "R4");          // 7*256+1 edges, byte order
        run(1'b1, 8, 1'b1, -1, "R5");          // page: 1153 edges
        run(1'b0, 8, 1'b1, -1, "R5");          // internal page, capture high
        run(1'b0, 2, 1'b1, 40, "R2");          // capture and start while busy ignored (R3)
        run(1'b0, 3, 1'b1, -1, "R10");         // ascending indices, internal

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule